// File: doc/BRIEF.md
# Multi-Channel Arrival Time Capture

This block timestamps the moment a signal reaches each of several sensors, measured against whichever sensor heard it first. Every channel delivers a one-bit comparator output that goes high when the sensed signal crosses a reference. A single free-running counter, shared by all channels, starts on the first rising edge seen on any channel. Each channel then stores the counter value at its own first rising edge. The earliest channel therefore holds zero, and every other channel holds its lag behind it in clock cycles.

Software arms the block with a one-cycle pulse. This clears all stored values and makes the block listen. When every channel has stored a value, the block raises a one-cycle completion pulse. The per-channel timestamps and a validity mask stay on the outputs until the next arm. If the shared counter reaches a programmable limit before every channel has fired, the capture ends early with an error flag. The channels that never fired are left marked invalid.

Top module: `arrival_capture`

## Requirements
- R1: After reset, `cap_done`, `cap_timeout`, every bit of `chan_valid` and every timestamp are zero, and no capture is in progress.
- R2: Once armed, the channel whose rising edge arrives first stores 0. A channel whose rising edge arrives k clock cycles later stores k. Both edges pass through the same two-flop synchronizer, so only the difference between them matters.
- R3: Channels whose first rising edges fall in the same cycle all store the same value. When all channels rise together, the capture finishes at once with every timestamp 0.
- R4: After a channel has stored its value, later falling and rising edges on that channel do not change its timestamp until the next arm.
- R5: Rising edges that occur while the block is not armed are ignored. This covers edges before the first arm and edges after a capture has finished. Such edges change neither `chan_valid` nor the timestamps, and they produce no `cap_done`.
- R6: When the last channel stores its value, `cap_done` is high for exactly one cycle with `cap_timeout` = 0 and `chan_valid` all ones. The results hold until the next arm.
- R7: If the shared counter reaches `TIMEOUT_CYCLES` before every channel has fired, the capture ends with a one-cycle `cap_done` and `cap_timeout` = 1. At that point `chan_valid` has bit i = 1 only for the channels that fired. A channel that never fired reads timestamp 0. A channel can store at most `TIMEOUT_CYCLES-1`, and an edge arriving exactly `TIMEOUT_CYCLES` cycles after the first one is not captured.
- R8: A one-cycle `arm` pulse clears all latches, timestamps, the counter and `cap_timeout`, whatever the current state. This includes a capture that is still in progress. An edge arriving in the same cycle as `arm` is not captured.
- R9: Only a low-to-high transition counts as an arrival. A channel that is already high when the block is armed is not captured until it goes low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle pulse: clear results and start listening |
| trig_in | input | NCH | Asynchronous comparator output per channel |
| cap_done | output | 1 | One-cycle pulse when a capture ends |
| cap_timeout | output | 1 | The last capture ended on the counter limit |
| chan_valid | output | NCH | Bit i set when channel i has stored a timestamp |
| stamps | output | NCH x CNT_W | Per-channel timestamps, channel i in slice i |

## Verification
The bench targets the following corner cases, and what a faulty design would show for each:

- **Channel order.** The channel that fires first is varied between runs. A design that tied the zero reference to channel 0 would report wrong, even negative, lags.
- **Ties.** Some runs have channels rising in the same cycle. An off-by-one at counter start would give the tied channels different values, or none of them zero.
- **Re-triggering.** Channels pulse again after storing. A latch that re-captured would show the later time.
- **Level already high at arm.** One run holds a channel high across the arm. A level-sensitive design would stamp that channel at zero.
- **Timeout boundary.** Edges arrive at exactly one cycle before and exactly at the counter limit. A design off by one there would include or drop the wrong channel.
- **Re-arm mid-capture.** An arm is issued while a capture is still running. A design that ignored it would leak the stale partial capture into the results.

// File: rtl/arrcap_pkg.sv
package arrcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } cap_state_e;

    typedef struct packed {
        logic finish;
        logic expired;
    } cap_end_t;

    function automatic logic is_listening(input cap_state_e st);
        return (st == ST_WAIT) || (st == ST_RUN);
    endfunction

endpackage

// File: rtl/arrcap_sync_edge.sv
module arrcap_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int TOP = SYNC_STAGES;

    logic [TOP:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[TOP-1:0], din};
        end
    end

    assign rise = sh[TOP-1] & ~sh[TOP];

endmodule

// File: rtl/arrcap_timer.sv
module arrcap_timer #(
    parameter int CNT_W          = 16,
    parameter int TIMEOUT_CYCLES = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (run) begin
            count <= count + 1'b1;
        end
    end

    assign hit = (count == LIMIT);

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        count <= LIMIT);

endmodule

// File: rtl/arrcap_chan.sv
module arrcap_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             take,
    input  logic [CNT_W-1:0] count,
    output logic             latched,
    output logic [CNT_W-1:0] stamp
);
    logic grab;
    assign grab = take & ~latched;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            latched <= 1'b0;
            stamp   <= '0;
        end else if (grab) begin
            latched <= 1'b1;
            stamp   <= count;
        end
    end

    assert_stamp_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (latched && !clr) |=> ($stable(stamp) && latched));

    assert_unlatched_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !latched |-> (stamp == '0));

endmodule

// File: rtl/arrival_capture.sv
module arrival_capture #(
    parameter int NCH            = 5,
    parameter int CNT_W          = 16,
    parameter int TIMEOUT_CYCLES = 1000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      arm,
    input  logic [NCH-1:0]            trig_in,
    output logic                      cap_done,
    output logic                      cap_timeout,
    output logic [NCH-1:0]            chan_valid,
    output logic [NCH-1:0][CNT_W-1:0] stamps
);
    import arrcap_pkg::*;

    cap_state_e       state;
    logic [NCH-1:0]   rise;
    logic [NCH-1:0]   take;
    logic [NCH-1:0]   latched;
    logic [NCH-1:0]   latched_nxt;
    logic [CNT_W-1:0] count;
    logic             hit;
    logic             listen;
    logic             complete;
    logic             timer_run;
    cap_end_t         ending;

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_chan
            arrcap_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .din  (trig_in[gi]),
                .rise (rise[gi])
            );
            arrcap_chan #(.CNT_W(CNT_W)) u_chan (
                .clk     (clk),
                .rst     (rst),
                .clr     (arm),
                .take    (take[gi]),
                .count   (count),
                .latched (latched[gi]),
                .stamp   (stamps[gi])
            );
        end
    endgenerate

    arrcap_timer #(.CNT_W(CNT_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (arm),
        .run   (timer_run),
        .count (count),
        .hit   (hit)
    );

    always_comb begin
        listen      = is_listening(state) && !arm && !((state == ST_RUN) && hit);
        take        = listen ? rise : '0;
        latched_nxt = latched | take;
        complete    = &latched_nxt;
        ending      = '{finish: 1'b0, expired: 1'b0};
        timer_run   = 1'b0;
        if (!arm) begin
            case (state)
                ST_WAIT: begin
                    timer_run     = |take;
                    ending.finish = complete;
                end
                ST_RUN: begin
                    ending.finish  = complete || hit;
                    ending.expired = !complete && hit;
                    timer_run      = !ending.finish;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cap_done    <= 1'b0;
            cap_timeout <= 1'b0;
        end else begin
            cap_done <= 1'b0;
            if (arm) begin
                state       <= ST_WAIT;
                cap_timeout <= 1'b0;
            end else if (ending.finish) begin
                state       <= ST_IDLE;
                cap_done    <= 1'b1;
                cap_timeout <= ending.expired;
            end else if ((state == ST_WAIT) && (|take)) begin
                state <= ST_RUN;
            end
        end
    end

    assign chan_valid = latched;

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        cap_done |=> !cap_done);

    assert_done_full_R6: assert property (@(posedge clk) disable iff (rst)
        (cap_done && !cap_timeout) |-> (&chan_valid));

    assert_timeout_partial_R7: assert property (@(posedge clk) disable iff (rst)
        (cap_done && cap_timeout) |-> !(&chan_valid));

    assert_arm_clears_R8: assert property (@(posedge clk) disable iff (rst)
        arm |=> (chan_valid == '0 && !cap_timeout && !cap_done));

    assert_first_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> (count == '0));

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) && !arm) |=> $stable(chan_valid));

endmodule

// File: tb/arrival_capture_test.sv
module arrival_capture_test;

    localparam int NCH = 5;
    localparam int W   = 16;
    localparam int LIM = 1000;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  arm = 1'b0;
    logic [NCH-1:0]        trig_in = '0;
    logic                  cap_done;
    logic                  cap_timeout;
    logic [NCH-1:0]        chan_valid;
    logic [NCH-1:0][W-1:0] stamps;

    int total = 0;
    int bad   = 0;
    int seen  = 0;
    int cycles = 0;

    typedef struct {
        logic                  err;
        logic [NCH-1:0]        mask;
        logic [NCH-1:0][W-1:0] st;
        string                 tag;
    } exp_t;

    exp_t q[$];

    arrival_capture #(.NCH(NCH), .CNT_W(W), .TIMEOUT_CYCLES(LIM)) uut (
        .clk         (clk),
        .rst         (rst),
        .arm         (arm),
        .trig_in     (trig_in),
        .cap_done    (cap_done),
        .cap_timeout (cap_timeout),
        .chan_valid  (chan_valid),
        .stamps      (stamps)
    );

    always #2.5 clk = ~clk;

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    // monitor: pop expected result on each completion pulse
    always @(negedge clk) begin
        if (!rst && cap_done) begin
            if (q.size() == 0) begin
                check(1'b0, "R5 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(cap_timeout == e.err, {e.tag, " timeout flag"}, cap_timeout, e.err);
                check(chan_valid == e.mask, {e.tag, " valid mask"}, chan_valid, e.mask);
                for (int i = 0; i < NCH; i++)
                    check(stamps[i] == e.st[i], {e.tag, " stamp"}, stamps[i], e.st[i]);
            end
            seen++;
        end
    end

    task automatic pulse_arm();
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
    endtask

    // first[i] < 0: channel never fires. glitch: drop and re-rise after storing.
    task automatic run_cap(input int first[NCH], input bit glitch, input string tag);
        exp_t e;
        int   mn = 1 << 30;
        int   mx = 0;
        int   target;
        for (int i = 0; i < NCH; i++) if (first[i] >= 0) begin
            if (first[i] < mn) mn = first[i];
            if (first[i] > mx) mx = first[i];
        end
        e.err = 1'b0; e.mask = '0; e.tag = tag;
        for (int i = 0; i < NCH; i++) begin
            e.st[i] = '0;
            if (first[i] >= 0 && first[i] - mn < LIM) begin
                e.mask[i] = 1'b1;
                e.st[i]   = W'(first[i] - mn);
            end
        end
        e.err = !(&e.mask);
        q.push_back(e);
        target = seen + 1;
        pulse_arm();
        for (int t = 0; t <= mx + 8; t++) begin
            for (int i = 0; i < NCH; i++) if (first[i] >= 0) begin
                if (t == first[i]) trig_in[i] = 1'b1;
                if (glitch && t == first[i] + 2) trig_in[i] = 1'b0;
                if (glitch && t == first[i] + 5) trig_in[i] = 1'b1;
            end
            @(negedge clk);
        end
        while (seen < target) @(negedge clk);
        trig_in = '0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        logic [NCH-1:0]        keep_v;
        logic [NCH-1:0][W-1:0] keep_s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cap_done == 0 && cap_timeout == 0, "R1 flags", {cap_done, cap_timeout}, 0);
        check(chan_valid == 0, "R1 valid", chan_valid, 0);
        check(stamps == '0, "R1 stamps", stamps[0], 0);

        // R5 edges before any arm
        trig_in = '1; repeat (4) @(negedge clk);
        trig_in = '0; repeat (4) @(negedge clk);
        check(chan_valid == 0, "R5 pre-arm valid", chan_valid, 0);

        // R2 staggered, earliest is channel 1
        run_cap('{7, 0, 12, 3, 20}, 1'b0, "R2 staggered");
        run_cap('{30, 18, 4, 9, 11}, 1'b0, "R2 reorder");
        // R3 ties and all-together
        run_cap('{5, 5, 9, 5, 14}, 1'b0, "R3 ties");
        run_cap('{2, 2, 2, 2, 2}, 1'b0, "R3 all same");
        // R4 re-triggers after storing
        run_cap('{0, 4, 8, 1, 2}, 1'b1, "R4 retrigger");

        // R5 edges after a finished capture
        keep_v = chan_valid; keep_s = stamps;
        trig_in = 5'b10101; repeat (4) @(negedge clk);
        trig_in = '0; repeat (3) @(negedge clk);
        trig_in = '1; repeat (4) @(negedge clk);
        trig_in = '0; repeat (4) @(negedge clk);
        check(chan_valid == keep_v, "R5 idle valid", chan_valid, keep_v);
        check(stamps == keep_s, "R5 idle stamps", stamps[4], keep_s[4]);

        // R9 channel 0 high across arm, rises again 17 cycles after channel 1
        begin
            exp_t e;
            int target;
            trig_in[0] = 1'b1; repeat (5) @(negedge clk);
            e.err = 0; e.mask = '1; e.tag = "R9 level at arm";
            e.st[0] = 17; e.st[1] = 0; e.st[2] = 1; e.st[3] = 2; e.st[4] = 3;
            q.push_back(e);
            target = seen + 1;
            pulse_arm();
            for (int t = 0; t <= 30; t++) begin
                if (t >= 3 && t <= 6) trig_in[t-2] = 1'b1;
                if (t == 15) trig_in[0] = 1'b0;
                if (t == 20) trig_in[0] = 1'b1;
                @(negedge clk);
            end
            while (seen < target) @(negedge clk);
            trig_in = '0; repeat (5) @(negedge clk);
        end

        // R7 timeout boundary: lag LIM-1 kept, lag LIM dropped
        run_cap('{0, LIM - 1, LIM, -1, -1}, 1'b0, "R7 timeout");
        check(cap_timeout == 1, "R7 flag held", cap_timeout, 1);

        // R8 arm clears after timeout
        pulse_arm();
        check(cap_timeout == 0 && chan_valid == 0, "R8 arm clears", {cap_timeout, chan_valid}, 0);
        // R8 re-arm mid-capture
        trig_in[0] = 1'b1; repeat (2) @(negedge clk);
        trig_in[1] = 1'b1; repeat (6) @(negedge clk);
        check(chan_valid != 0, "R8 partial latched", chan_valid, 3);
        pulse_arm();
        check(chan_valid == 0, "R8 re-arm clears", chan_valid, 0);
        trig_in = '0; repeat (5) @(negedge clk);
        run_cap('{1, 0, 3, 2, 4}, 1'b0, "R8 after re-arm");

        check(q.size() == 0, "R6 all results seen", q.size(), 0);
        finish_run();
    end

endmodule